// File: doc/BRIEF.md
# Chained Serial Frame Receiver

This block is the receive side of one node in a string of devices that share a single serial data line from a host. Inside a window where the active-low select is held low, the host clocks in a 10-bit frame, most significant bit first: a 2-bit channel number followed by an 8-bit value. Every bit that falls off the far end of the 10-bit shift register is sent on to the next device through an open-drain output. One long burst can therefore fill several devices. The first frame sent travels furthest down the string, and the last frame sent stays in the nearest device.

The serial clock, data and select pins are asynchronous to the system clock. They are synchronized and oversampled in that clock domain. Data is captured on serial clock rising edges. The pass-through bit changes on falling edges, so it is stable when the next device samples it. When the select is released, the current register contents are committed to the channel and value outputs, and a load strobe pulses for one system clock. The frame length is not checked: whatever 10 bits were shifted in last are what get committed.

Top module: `spi_chain_frame_reg`

## Requirements
- R1: While the select is low, each serial clock rising edge shifts the data bit into bit 0 of the 10-bit register, so the bits end up MSB first.
- R2: On select release, the channel output takes register bits [9:8] and the value output takes register bits [7:0].
- R3: Bursts shorter or longer than 10 clocks commit the last 10 bits shifted in, counting bits from earlier bursts when the burst was short. No error indication exists.
- R4: The pass-through bit is register bit 9 and changes only on serial clock falling edges. In a 20-clock burst, the next device sees the first 10 bits at rising edges 11 to 20.
- R5: The output pull-low is asserted only while the select is low and the pass-through bit is 0. It never drives a 1, and it is released while the select is high.
- R6: Serial clock edges while the select is high change neither the register nor the pass-through bit.
- R7: Each select release gives exactly one load strobe, one system clock wide, in the same cycle that the channel and value outputs update.
- R8: After reset, the register, the pass-through bit, the channel, the value and the strobe are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from host or previous device |
| sdi | input | 1 | Serial data in |
| cs_n | input | 1 | Active-low frame select |
| sdo_pull_low | output | 1 | Open-drain enable: 1 pulls the downstream data line low |
| load_stb | output | 1 | One-cycle commit strobe |
| chan_o | output | ADDR_W | Committed channel number |
| val_o | output | DATA_W | Committed channel value |

## Verification
The bench acts as the downstream device. Just before every rising edge it samples the pull-low output and compares it with a model of bit 9. A design that updated the pass-through on the rising edge would give the next device its bits one position late, and the 20-clock chain check would fail. The bench also sends a 6-bit burst and a 20-bit burst. A design that cleared the register on select assertion, or that kept the first 10 bits instead of the last 10, would commit the wrong channel and value. Finally, the serial clock toggles with the data high while the select is high, followed by an empty select pulse. A design that shifted anyway would commit ones and hold the line released at the wrong time.

// File: rtl/spi_chain_frame_reg.sv
module spi_chain_frame_reg #(
  parameter int ADDR_W      = 2,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              sdi,
  input  logic              cs_n,
  output logic              sdo_pull_low,
  output logic              load_stb,
  output logic [ADDR_W-1:0] chan_o,
  output logic [DATA_W-1:0] val_o
);
  localparam int FRAME_W = ADDR_W + DATA_W;

  logic [SYNC_STAGES-1:0] sclk_sy, sdi_sy, csn_sy;
  logic                   sclk_d, csn_d;
  logic [FRAME_W-1:0]     sr;
  logic                   sdo_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_sy <= '0;
      sdi_sy  <= '0;
      csn_sy  <= '1;
      sclk_d  <= 1'b0;
      csn_d   <= 1'b1;
    end else begin
      sclk_sy <= {sclk_sy[SYNC_STAGES-2:0], sclk};
      sdi_sy  <= {sdi_sy[SYNC_STAGES-2:0], sdi};
      csn_sy  <= {csn_sy[SYNC_STAGES-2:0], cs_n};
      sclk_d  <= sclk_sy[SYNC_STAGES-1];
      csn_d   <= csn_sy[SYNC_STAGES-1];
    end
  end

  wire sclk_s    = sclk_sy[SYNC_STAGES-1];
  wire sdi_s     = sdi_sy[SYNC_STAGES-1];
  wire csn_s     = csn_sy[SYNC_STAGES-1];
  wire sclk_rise = sclk_s & ~sclk_d & ~csn_s;
  wire sclk_fall = ~sclk_s & sclk_d & ~csn_s;
  wire cs_rel    = csn_s & ~csn_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr      <= '0;
      sdo_bit <= 1'b0;
    end else begin
      if (sclk_rise) sr <= {sr[FRAME_W-2:0], sdi_s};
      if (sclk_fall) sdo_bit <= sr[FRAME_W-1];
    end
  end

  assign sdo_pull_low = ~csn_s & ~sdo_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_stb <= 1'b0;
      chan_o   <= '0;
      val_o    <= '0;
    end else begin
      load_stb <= cs_rel;
      if (cs_rel) begin
        chan_o <= sr[FRAME_W-1:DATA_W];
        val_o  <= sr[DATA_W-1:0];
      end
    end
  end

  // R1: new bit lands in bit 0 after a rising edge
  a_r1_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_s && !sclk_d && !csn_s) |=> (sr[0] == $past(sdi_s)));
  // R2: committed fields match the register of the release cycle
  a_r2_commit: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |-> ({chan_o, val_o} == $past(sr)));
  // R4: pass-through bit moves only on falling edges
  a_r4_fall_only: assert property (@(posedge clk) disable iff (!rst_n)
    !(sclk_d && !sclk_s) |=> $stable(sdo_bit));
  // R6: no shifting while deselected
  a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    csn_s |=> $stable(sr));
  // R5: line released while deselected
  a_r5_released: assert property (@(posedge clk) disable iff (!rst_n)
    csn_s |-> !sdo_pull_low);
  // R7: strobe is one cycle wide
  a_r7_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |=> !load_stb);
endmodule

// File: tb/spi_chain_frame_reg_tb.sv
`timescale 1ns/1ps
module spi_chain_frame_reg_tb;
  localparam int H = 6;

  logic       clk = 0, rst_n = 0, sclk = 0, sdi = 0, cs_n = 1;
  logic       sdo_pull_low, load_stb;
  logic [1:0] chan_o;
  logic [7:0] val_o;

  int checks = 0, errors = 0, loads_seen = 0, loads_exp = 0;
  logic [9:0] hist = '0;
  logic       obs [0:63];
  logic [9:0] exp_q [$];
  string      tag_q [$];

  always #4 clk = ~clk;

  spi_chain_frame_reg u_dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdi(sdi), .cs_n(cs_n),
    .sdo_pull_low(sdo_pull_low), .load_stb(load_stb),
    .chan_o(chan_o), .val_o(val_o));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(posedge clk);
  endtask

  // Driver: shifts n bits MSB first, acts as downstream sampler, pushes expected commit
  task automatic burst(input logic [63:0] bits, input int n, input string tag);
    cs_n = 0;
    wclk(H);
    for (int i = 0; i < n; i++) begin
      sdi = bits[n-1-i];
      wclk(H);
      @(negedge clk);
      obs[i] = ~sdo_pull_low;
      chk(sdo_pull_low == ~hist[9], "R4/R5 pass-through", sdo_pull_low, ~hist[9]);
      sclk = 1;
      hist = {hist[8:0], bits[n-1-i]};
      wclk(H);
      sclk = 0;
    end
    wclk(H);
    exp_q.push_back(hist);
    tag_q.push_back(tag);
    loads_exp++;
    cs_n = 1;
    wclk(2*H);
    @(negedge clk);
    chk(sdo_pull_low == 0, "R5 released when deselected", sdo_pull_low, 0);
  endtask

  // Monitor: pops expected commits on each strobe
  logic prev_stb = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (load_stb) begin
        loads_seen++;
        chk(!prev_stb, "R7 strobe width", 1, 0);
        if (exp_q.size() == 0) chk(0, "R7 unexpected strobe", 1, 0);
        else begin
          logic [9:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(chan_o == e[9:8], {t, " R2 channel"}, chan_o, e[9:8]);
          chk(val_o == e[7:0], {t, " R2 value"}, val_o, e[7:0]);
        end
      end
      prev_stb <= load_stb;
    end
  end

  initial begin
    #(8.0 * 200000);
    chk(0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wclk(3);
    @(negedge clk);
    chk(load_stb == 0 && chan_o == 0 && val_o == 0, "R8 reset outputs", {load_stb, chan_o, val_o}, 0);
    chk(sdo_pull_low == 0, "R8 line released in reset", sdo_pull_low, 0);
    rst_n = 1;
    wclk(4);

    burst(64'b10_1010_0101, 10, "R1 frame A");
    burst(64'b01_0011_1100, 10, "R1 frame B");
    burst(64'b11_1111_1111, 10, "R1 all ones");
    burst(64'b00_0000_0000, 10, "R1 all zeros");
    burst(64'b01_1011_0110, 10, "R1 frame C");
    burst(64'b110010, 6, "R3 short burst");

    burst(64'b10_0110_1001_00_1100_1010, 20, "R3 long burst");
    for (int i = 0; i < 10; i++) begin
      logic eb;
      eb = 20'b10_0110_1001_00_1100_1010 >> (19 - i);
      chk(obs[10+i] == eb, "R4 chain bit to next device", obs[10+i], eb);
    end

    // R6: clocks with sdi high while deselected, then an empty select pulse
    sdi = 1;
    for (int i = 0; i < 5; i++) begin
      wclk(H); sclk = 1; wclk(H); sclk = 0;
      @(negedge clk);
      chk(sdo_pull_low == 0, "R5/R6 idle clocks keep line released", sdo_pull_low, 0);
    end
    burst(64'h0, 0, "R6 idle clocks ignored");
    burst(64'b00_1000_0001, 10, "R1 after idle");

    wclk(10);
    chk(exp_q.size() == 0 && loads_seen == loads_exp, "R7 one strobe per release", loads_seen, loads_exp);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule